// File: doc/BRIEF.md
# Banked Gather/Scatter Conflict Arbiter

This block serves vector memory accesses whose sixteen lanes each carry an arbitrary element address, so access is irregular rather than strided. A vector is either a gather, which reads one word per lane, or a scatter, which writes one word per lane. Each element address is split into a bank index and a row. Every bank grants at most one lane per cycle. Lanes that lose arbitration are parked in a per-lane conflict slot and retried on the following cycles. They are not pushed back to the issuing pipeline.

Arbitration runs in the same cycle the vector is accepted. Winning lanes reach their bank at that clock edge: a scatter writes there, and a gather gets its read word one cycle later. Results from lanes served in different cycles are collected into one lane-ordered vector. A single one-cycle completion pulse marks the end of the vector. A vector with no bank conflicts leaves the input ready high, so such vectors can be accepted every cycle. The banks are modelled as single-port arrays inside the block.

Top module: `vgs_gather_scatter`

## Requirements
- R1: A lane's bank is element address bits [3:0] and its row is bits [9:4]. A gather lane returns the word most recently scattered to that same bank and row.
- R2: Each bank serves at most one lane per cycle. Among the lanes contending for a bank, the lowest-numbered lane is served first.
- R3: Lanes that lose arbitration are held and retried on later cycles until served. `in_ready` is low while any lane is held, and no vector is accepted during that time.
- R4: A vector with at most one lane per bank is fully served in its accept cycle. `in_ready` stays high, so a new vector can be accepted on the very next cycle.
- R5: A scatter writes each lane at its grant. When several lanes of one scatter hit the same address, the highest-numbered lane's data is the final memory content.
- R6: For a gather, lane i's word appears at `out_rdata[i*32 +: 32]`.
- R7: Let k be the largest number of lanes of a vector that share one bank. `out_valid` is high for exactly one cycle, k+1 cycles after the accept edge. The vector is accepted at a rising edge; counting falling edges after it, `out_valid` is seen high at the (k+1)-th.
- R8: For a vector that shares a bank among k lanes, `in_ready` is low for exactly k-1 cycles after the accept edge.
- R9: After reset, `in_ready` is high, `out_valid` is low and `out_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A vector request is presented |
| in_ready | output | 1 | The block can accept a vector this cycle |
| in_store | input | 1 | 1 = scatter (write), 0 = gather (read) |
| in_addr | input | 160 | Sixteen 10-bit element addresses; lane i at [i*10 +: 10] |
| in_wdata | input | 512 | Sixteen 32-bit scatter words; lane i at [i*32 +: 32] |
| out_valid | output | 1 | One-cycle pulse: the vector has been fully served |
| out_rdata | output | 512 | Gather result, lane i at [i*32 +: 32] |

## Verification
The assertions assume that every accepted vector uses all sixteen lanes. They also assume that inputs stay frozen while `in_ready` is low, so a held lane never sees its source change before it is served. The bench drives inputs only on falling edges. It keeps each request asserted until the block accepts it and drops it right after the accept edge. It gathers only addresses that it has already scattered, so no read ever returns an unwritten memory word.

// File: rtl/vgs_pkg.sv
package vgs_pkg;
  typedef enum logic {
    VGS_GATHER  = 1'b0,
    VGS_SCATTER = 1'b1
  } vgs_op_e;
endpackage

// File: rtl/vgs_lane_slot.sv
// Per-lane conflict slot: holds a lane that lost bank arbitration.
module vgs_lane_slot #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,      // vector accepted this cycle
  input  logic [AW-1:0] new_addr,
  input  logic [DW-1:0] new_wdata,
  input  logic          gnt,       // lane served by its bank this cycle
  output logic          req,
  output logic [AW-1:0] cur_addr,
  output logic [DW-1:0] cur_wdata,
  output logic          pending
);
  logic          pend_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  assign pending   = pend_q;
  assign req       = load | pend_q;
  assign cur_addr  = pend_q ? addr_q : new_addr;
  assign cur_wdata = pend_q ? data_q : new_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (load && !pend_q) begin
        addr_q <= new_addr;
        data_q <= new_wdata;
      end
      pend_q <= req & ~gnt;
    end
  end

  // R3: a parked lane stays parked, with its address intact, until granted
  a_r3_slot_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !gnt) |=> (pend_q && $stable(addr_q) && $stable(data_q)));

  // R3: a lane is never granted without a live request
  a_r3_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    gnt |-> req);
endmodule

// File: rtl/vgs_bank_arb.sv
// Fixed-priority arbiter for one bank: the lowest lane number wins.
module vgs_bank_arb #(
  parameter int LANES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] req,
  output logic [LANES-1:0] gnt
);
  // isolate the lowest set bit
  function automatic logic [LANES-1:0] lowest_bit(input logic [LANES-1:0] v);
    return v & (~v + 1'b1);
  endfunction

  assign gnt = lowest_bit(req);

  // R2: one lane per bank per cycle
  a_r2_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R2: no requester below the winner
  a_r2_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0) |-> ((req & (gnt - 1'b1)) == '0));

  // R3: a contended bank always makes progress
  a_r3_bank_progress: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |-> ($countones(gnt) == 1));
endmodule

// File: rtl/vgs_bank_mem.sv
// Single-port bank array: write or registered read, one per cycle.
module vgs_bank_mem #(
  parameter int RW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [RW-1:0] row,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << RW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[row] <= wdata;
      else    rdata    <= mem[row];
    end
  end
endmodule

// File: rtl/vgs_gather_scatter.sv
module vgs_gather_scatter
  import vgs_pkg::*;
#(
  parameter int LANES = 16,
  parameter int BANKS = 16,
  parameter int AW    = 10,
  parameter int DW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_store,
  input  logic [LANES*AW-1:0] in_addr,
  input  logic [LANES*DW-1:0] in_wdata,
  output logic                out_valid,
  output logic [LANES*DW-1:0] out_rdata
);
  localparam int BB = $clog2(BANKS);
  localparam int RW = AW - BB;

  // address split: low bits pick the bank, the rest pick the row
  function automatic logic [BB-1:0] bank_of(input logic [AW-1:0] a);
    return a[BB-1:0];
  endfunction
  function automatic logic [RW-1:0] row_of(input logic [AW-1:0] a);
    return a[AW-1:BB];
  endfunction

  // ---------------- accept and lane slots ----------------
  logic             accept;
  vgs_op_e          op_q, cur_op;
  logic [LANES-1:0] lane_req, lane_gnt, slot_pend;
  logic [AW-1:0]    lane_addr  [LANES];
  logic [DW-1:0]    lane_wdata [LANES];

  assign in_ready = ~|slot_pend;
  assign accept   = in_valid & in_ready;
  assign cur_op   = accept ? vgs_op_e'(in_store) : op_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      op_q <= VGS_GATHER;
    else if (accept) op_q <= vgs_op_e'(in_store);
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    vgs_lane_slot #(.AW(AW), .DW(DW)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .new_addr  (in_addr[i*AW +: AW]),
      .new_wdata (in_wdata[i*DW +: DW]),
      .gnt       (lane_gnt[i]),
      .req       (lane_req[i]),
      .cur_addr  (lane_addr[i]),
      .cur_wdata (lane_wdata[i]),
      .pending   (slot_pend[i])
    );
  end

  // ---------------- per-bank arbitration ----------------
  logic [LANES-1:0] bank_req [BANKS];
  logic [LANES-1:0] bank_gnt [BANKS];
  logic [DW-1:0]    bank_rdata [BANKS];

  always_comb begin
    for (int b = 0; b < BANKS; b++) begin
      for (int i = 0; i < LANES; i++) begin
        bank_req[b][i] = lane_req[i] && (bank_of(lane_addr[i]) == BB'(b));
      end
    end
  end

  always_comb begin
    lane_gnt = '0;
    for (int b = 0; b < BANKS; b++) lane_gnt = lane_gnt | bank_gnt[b];
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [RW-1:0] sel_row;
    logic [DW-1:0] sel_wdata;

    vgs_bank_arb #(.LANES(LANES)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (bank_req[b]),
      .gnt   (bank_gnt[b])
    );

    // one-hot grant drives an OR-mux of the winning lane
    always_comb begin
      sel_row   = '0;
      sel_wdata = '0;
      for (int i = 0; i < LANES; i++) begin
        if (bank_gnt[b][i]) begin
          sel_row   = sel_row | row_of(lane_addr[i]);
          sel_wdata = sel_wdata | lane_wdata[i];
        end
      end
    end

    vgs_bank_mem #(.RW(RW), .DW(DW)) u_mem (
      .clk   (clk),
      .en    (|bank_gnt[b]),
      .we    (cur_op == VGS_SCATTER),
      .row   (sel_row),
      .wdata (sel_wdata),
      .rdata (bank_rdata[b])
    );
  end

  // ---------------- data synchronisation ----------------
  logic             served_last;   // last lanes of the vector granted now
  logic             fin_q;
  logic             out_valid_q;
  logic [LANES-1:0] rd_gnt_q;
  logic [BB-1:0]    rd_bank_q [LANES];
  logic [DW-1:0]    result_q  [LANES];

  assign served_last = (|lane_req) && ((lane_req & ~lane_gnt) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fin_q       <= 1'b0;
      out_valid_q <= 1'b0;
      rd_gnt_q    <= '0;
      for (int i = 0; i < LANES; i++) begin
        rd_bank_q[i] <= '0;
        result_q[i]  <= '0;
      end
    end else begin
      fin_q       <= served_last;
      out_valid_q <= fin_q;
      rd_gnt_q    <= (cur_op == VGS_GATHER) ? lane_gnt : '0;
      for (int i = 0; i < LANES; i++) begin
        rd_bank_q[i] <= bank_of(lane_addr[i]);
        if (rd_gnt_q[i]) result_q[i] <= bank_rdata[rd_bank_q[i]];
      end
    end
  end

  assign out_valid = out_valid_q;
  always_comb begin
    for (int i = 0; i < LANES; i++) out_rdata[i*DW +: DW] = result_q[i];
  end

  // R3: while lanes are parked, every cycle serves at least one of them
  a_r3_parked_progress: assert property (@(posedge clk) disable iff (!rst_n)
    (|slot_pend) |-> (|(lane_gnt & slot_pend)));

  // R3: no new vector is taken while any lane is parked
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (|slot_pend) |-> !accept);

  // R7: completion follows the last grant by two edges
  a_r7_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
    served_last |-> ##2 out_valid);

  // R7: completion only after lanes were served
  a_r7_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(fin_q));
endmodule

// File: tb/vgs_gather_scatter_test.sv
`timescale 1ns/1ps
module vgs_gather_scatter_test;
  localparam int L = 16;
  localparam int AW = 10;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_store = 1'b0;
  logic [L*AW-1:0] in_addr = '0;
  logic [L*DW-1:0] in_wdata = '0;
  logic in_ready, out_valid;
  logic [L*DW-1:0] out_rdata;

  int checks = 0;
  int failures = 0;

  logic [DW-1:0] ref_mem [1024];
  logic [AW-1:0] va [L];
  logic [DW-1:0] vd [L];
  logic [31:0]   lfsr = 32'h1ACE_B00C;

  always #4 clk = ~clk;  // 125 MHz

  vgs_gather_scatter uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_store(in_store), .in_addr(in_addr), .in_wdata(in_wdata),
    .out_valid(out_valid), .out_rdata(out_rdata)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench's own restatement of the bank split and contention depth
  function automatic int depth_of();
    int cnt [L];
    int best = 0;
    for (int b = 0; b < L; b++) cnt[b] = 0;
    for (int i = 0; i < L; i++) cnt[va[i] % 16]++;
    for (int b = 0; b < L; b++) if (cnt[b] > best) best = cnt[b];
    return best;
  endfunction

  function automatic logic [31:0] step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  // send va/vd as one vector; check timing (R7, R8), data (R1, R6), model (R5)
  task automatic run_vec(input logic st, input string tag);
    int k, n, low;
    k = depth_of();
    in_store = st;
    for (int i = 0; i < L; i++) begin
      in_addr[i*AW +: AW]  = va[i];
      in_wdata[i*DW +: DW] = vd[i];
    end
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    n = 1;
    low = 0;
    while (!out_valid && n < 40) begin
      if (!in_ready) low++;
      @(negedge clk);
      n++;
    end
    check(n == k + 1, {"R7 done latency ", tag}, n, k + 1);
    check(low == k - 1, {"R8 ready low cycles ", tag}, low, k - 1);
    if (st) begin
      for (int i = 0; i < L; i++) ref_mem[va[i]] = vd[i];  // R5: ascending lanes
    end else begin
      for (int i = 0; i < L; i++)
        check(out_rdata[i*DW +: DW] === ref_mem[va[i]], {"R1 R6 gather data ", tag},
              out_rdata[i*DW +: DW], ref_mem[va[i]]);
    end
    @(negedge clk);
    check(out_valid == 1'b0, {"R7 single pulse ", tag}, out_valid, 0);
  endtask

  task automatic t_reset();
    check(in_ready == 1'b1, "R9 ready after reset", in_ready, 1);
    check(out_valid == 1'b0, "R9 valid after reset", out_valid, 0);
    check(out_rdata == '0, "R9 data after reset", out_rdata[31:0], 0);
  endtask

  // fill all memory with conflict-free scatters (R4: one lane per bank)
  task automatic t_fill();
    for (int v = 0; v < 64; v++) begin
      for (int i = 0; i < L; i++) begin
        va[i] = AW'(v * 16 + i);
        vd[i] = 32'hC000_0000 ^ (v << 8) ^ i;
      end
      run_vec(1'b1, "fill");
    end
  endtask

  // R1 R6: gather a permuted conflict-free pattern
  task automatic t_gather_spread();
    for (int i = 0; i < L; i++) va[i] = AW'(((15 - i) << 4) | ((i * 7) % 16));
    run_vec(1'b0, "spread");
  endtask

  // R2 R3 R8: all sixteen lanes in bank 5
  task automatic t_one_bank();
    for (int i = 0; i < L; i++) begin
      va[i] = AW'((i * 3 % 64) << 4 | 5);
      vd[i] = 32'h5A00_0000 + i;
    end
    run_vec(1'b1, "bank5 scatter");
    run_vec(1'b0, "bank5 gather");
  endtask

  // R5: all lanes scatter one address, highest lane must remain
  task automatic t_same_addr();
    for (int i = 0; i < L; i++) begin
      va[i] = 10'h2A7;
      vd[i] = 32'hEE00_0000 + i;
    end
    run_vec(1'b1, "same addr");
    for (int i = 0; i < L; i++) va[i] = 10'h2A7;
    run_vec(1'b0, "same addr read");
    check(out_rdata[31:0] == 32'hEE00_000F, "R5 highest lane wins",
          out_rdata[31:0], 32'hEE00_000F);
  endtask

  // R2: two lanes pairing on each of eight banks, lane 9 after lane 1
  task automatic t_pairs();
    for (int i = 0; i < L; i++) begin
      va[i] = AW'((i % 8) | (7 << 4));
      vd[i] = 32'h9900_0000 + i;
    end
    run_vec(1'b1, "pairs");
    check(ref_mem[10'h071] == 32'h9900_0009, "R2 later lane after lower",
          ref_mem[10'h071], 32'h9900_0009);
    run_vec(1'b0, "pairs read");
  endtask

  // R4: two conflict-free gathers on back-to-back cycles
  task automatic t_back_to_back();
    logic [L*AW-1:0] a1, a2;
    for (int i = 0; i < L; i++) begin
      a1[i*AW +: AW] = AW'((i << 4) | i);
      a2[i*AW +: AW] = AW'((i << 4) | (15 - i));
    end
    in_store = 1'b0;
    in_addr  = a1;
    in_valid = 1'b1;
    check(in_ready == 1'b1, "R4 ready before first", in_ready, 1);
    @(posedge clk); @(negedge clk);
    check(in_ready == 1'b1, "R4 ready next cycle", in_ready, 1);
    in_addr = a2;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R4 first done", out_valid, 1);
    for (int i = 0; i < L; i++)
      check(out_rdata[i*DW +: DW] === ref_mem[a1[i*AW +: AW]], "R4 first data",
            out_rdata[i*DW +: DW], ref_mem[a1[i*AW +: AW]]);
    @(negedge clk);
    check(out_valid == 1'b1, "R4 second done", out_valid, 1);
    for (int i = 0; i < L; i++)
      check(out_rdata[i*DW +: DW] === ref_mem[a2[i*AW +: AW]], "R4 second data",
            out_rdata[i*DW +: DW], ref_mem[a2[i*AW +: AW]]);
    @(negedge clk);
    check(out_valid == 1'b0, "R7 pulse ends", out_valid, 0);
  endtask

  // mixed pseudo-random vectors, some squeezed onto four banks
  task automatic t_random();
    for (int v = 0; v < 24; v++) begin
      for (int i = 0; i < L; i++) begin
        lfsr = step(lfsr);
        va[i] = (v % 3 == 0) ? {lfsr[9:4], 2'b00, lfsr[1:0]} : lfsr[9:0];
        lfsr = step(lfsr);
        vd[i] = lfsr;
      end
      run_vec(v[0], "random");
    end
  endtask

  initial begin
    #(8ns * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_gather_spread();
    t_one_bank();
    t_same_addr();
    t_pairs();
    t_back_to_back();
    t_random();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule